// File: doc/BRIEF.md
# Shared-Store Message Queue Manager

This block lets processors exchange fixed-size messages through 64 hardware queues. The 64 queues draw their message slots from one common slot store. Software picks a queue with a queue index and then uses a small window of word registers for that queue. Offset 0 is a status word. Offsets 16 to 31 are sixteen 32-bit payload words.

To send, software writes payload words into the window and then writes offset 31. That last write places the whole 16-word message into a free slot and links the slot to the tail of the chosen queue. To receive, software reads the payload words of the message at the head of the queue and then reads offset 31. That last read returns the final word and releases the slot. Only full-word accesses have any effect, so a split or narrow access can never commit or drop a message by accident.

The queue depth is 128 messages. The shared store holds 160 slots. Each queue is marked as receive or transmit by a parameter mask. A receive queue drives its interrupt line while it holds at least one message. There is no threshold interrupt. Software reads the status word to learn how many messages are pending.

Top module: `msgq_mgr`

## Requirements
- R1: After reset, every queue holds 0 messages, all `irq` bits are low, and a status read of any queue returns 0.
- R2: A full-word write (regSize = 2'b10) to offset 16..30 stores that word in a staging buffer at position offset-16. A full-word write to offset 31 commits the staged words 0..14, with the written word as word 15, as one message at the tail of the selected queue. The queue's count then rises by one.
- R3: A full-word read of offset 16..30 returns the matching word of the head message and leaves it in place. A full-word read of offset 31 returns word 15 and removes the head message. Messages in one queue leave in the order they were committed.
- R4: A payload word that was not written before a commit reads back as zero. The staging buffer is cleared after every write to offset 31, whether or not the commit succeeds.
- R5: A full-word data write aimed at a different queue than the one whose message is being staged first discards the partly staged words.
- R6: A byte (regSize 2'b00) or halfword (2'b01) access has no effect at any offset. A write of that size to offset 31 does not commit, a read of that size does not pop, and a read of that size returns zero.
- R7: A full-word read of offset 0 returns the pending count in bits [7:0], the sticky overflow flag in bit 16 and the sticky underflow flag in bit 17. A full-word write to offset 0 clears each flag whose bit position is written as 1.
- R8: A commit to a queue that already holds 128 messages is dropped. The count stays unchanged and the queue's overflow flag is set.
- R9: A commit made while all 160 shared slots are in use is dropped, and the target queue's overflow flag is set.
- R10: A full-word read of offset 31 on an empty queue returns zero, leaves the count at zero and sets that queue's underflow flag. A read of offset 16..30 on an empty queue returns zero.
- R11: `irq[q]` is high exactly when RX_MASK bit q is 1 and queue q holds at least one message. It follows the count one cycle after the commit or pop.
- R12: Every read request, full-word or not, gives `rspValid` high with its data in the following cycle. A write request gives no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regReq | input | 1 | Access request, one cycle per access |
| regWe | input | 1 | 1 = write, 0 = read |
| regSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| regQueue | input | 6 | Selected queue index |
| regWord | input | 5 | Word offset in the queue window |
| regWdata | input | 32 | Write data |
| rspValid | output | 1 | Read response valid |
| rspData | output | 32 | Read response data |
| irq | output | 64 | Per-queue interrupt, receive queues only |

## Verification
Read data and `rspValid` are registered once, so they are due in the cycle after the request edge. The bench drives each request at a falling edge and samples the response at the next falling edge. Counts, flags and `irq` change at the same edge as the commit or pop that caused them, so a status read or `irq` sample made in the next access already shows the new state. The bench checks `irq` after every access for that reason, and checks the status word through a separate read that comes after the access being tested.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int NUM_Q     = 64;
  localparam int WIN_WORDS = 16;
  localparam int WIN_BASE  = 16;
  localparam int Q_DEPTH   = 128;
  localparam int NUM_SLOTS = 160;
  localparam int DATA_W    = 32;

  localparam int QW   = $clog2(NUM_Q);
  localparam int SW   = $clog2(NUM_SLOTS);
  localparam int CW   = $clog2(Q_DEPTH + 1);
  localparam int FCW  = $clog2(NUM_SLOTS + 1);
  localparam int WW   = $clog2(WIN_WORDS);
  localparam int OFFW = $clog2(WIN_BASE + WIN_WORDS);

  localparam int STAT_OVF_BIT = 16;
  localparam int STAT_UDF_BIT = 17;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef struct packed {
    logic              stageWr;   // store one payload word in staging
    logic              discard;   // drop staged words before this write
    logic              lastWr;    // last-word write: clear staging after
    logic [WW-1:0]     idx;       // payload word index
    logic              commit;    // write staged message into a slot
    logic [SW-1:0]     wrSlot;
    logic              rdEn;      // any read: respond next cycle
    logic              rdHead;    // read a word of the head message
    logic [SW-1:0]     rdSlot;
    logic              rdStat;    // return status word
    logic [DATA_W-1:0] statWord;
  } dp_strobe_t;
endpackage

// File: rtl/msgq_ctrl.sv
module msgq_ctrl
  import msgq_pkg::*;
#(
  parameter logic [NUM_Q-1:0] RX_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regReq,
  input  logic              regWe,
  input  logic [1:0]        regSize,
  input  logic [QW-1:0]     regQueue,
  input  logic [OFFW-1:0]   regWord,
  input  logic [DATA_W-1:0] regWdata,
  output dp_strobe_t        strb,
  output logic [NUM_Q-1:0]  irq,
  output logic [FCW-1:0]    freeCount
);
  logic [CW-1:0] cnt      [NUM_Q];
  logic [SW-1:0] headPtr  [NUM_Q];
  logic [SW-1:0] tailPtr  [NUM_Q];
  logic [SW-1:0] nextPtr  [NUM_SLOTS];
  logic [NUM_Q-1:0] ovfFlag, udfFlag;
  logic [SW-1:0] freeHead;
  logic [FCW-1:0] freeCnt;
  logic [QW-1:0] stageQ;

  logic legal, wrOp, rdOp, isData, isLast, isStat;
  logic [OFFW-1:0] rel;
  logic [CW-1:0] qCnt;
  logic qEmpty, canPush, doPush, dropPush, doPop, badPop, switchQ;

  always_comb begin
    legal    = regReq && (regSize == SIZE_WORD);
    wrOp     = legal && regWe;
    rdOp     = legal && !regWe;
    isData   = regWord >= OFFW'(WIN_BASE);
    rel      = regWord - OFFW'(WIN_BASE);
    isLast   = isData && (rel[WW-1:0] == WW'(WIN_WORDS - 1));
    isStat   = regWord == '0;
    qCnt     = cnt[regQueue];
    qEmpty   = qCnt == '0;
    canPush  = (qCnt != CW'(Q_DEPTH)) && (freeCnt != '0);
    doPush   = wrOp && isLast && canPush;
    dropPush = wrOp && isLast && !canPush;
    doPop    = rdOp && isLast && !qEmpty;
    badPop   = rdOp && isLast && qEmpty;
    switchQ  = wrOp && isData && (regQueue != stageQ);
  end

  always_comb begin
    strb          = '0;
    strb.stageWr  = wrOp && isData && !isLast;
    strb.discard  = switchQ;
    strb.lastWr   = wrOp && isLast;
    strb.idx      = rel[WW-1:0];
    strb.commit   = doPush;
    strb.wrSlot   = freeHead;
    strb.rdEn     = regReq && !regWe;
    strb.rdHead   = rdOp && isData && !qEmpty;
    strb.rdSlot   = headPtr[regQueue];
    strb.rdStat   = rdOp && isStat;
    strb.statWord[CW-1:0]     = qCnt;
    strb.statWord[STAT_OVF_BIT] = ovfFlag[regQueue];
    strb.statWord[STAT_UDF_BIT] = udfFlag[regQueue];
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_irq
    if (RX_MASK[q]) begin : g_rx
      assign irq[q] = cnt[q] != '0;
    end else begin : g_tx
      assign irq[q] = 1'b0;
    end
  end

  assign freeCount = freeCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_Q; q++) begin
        cnt[q]     <= '0;
        headPtr[q] <= '0;
        tailPtr[q] <= '0;
      end
      for (int s = 0; s < NUM_SLOTS; s++) begin
        nextPtr[s] <= SW'((s + 1) % NUM_SLOTS);
      end
      ovfFlag  <= '0;
      udfFlag  <= '0;
      freeHead <= '0;
      freeCnt  <= FCW'(NUM_SLOTS);
      stageQ   <= '0;
    end else begin
      if (wrOp && isData && !isLast) begin
        stageQ <= regQueue;
      end
      if (wrOp && isStat) begin
        if (regWdata[STAT_OVF_BIT]) ovfFlag[regQueue] <= 1'b0;
        if (regWdata[STAT_UDF_BIT]) udfFlag[regQueue] <= 1'b0;
      end
      if (dropPush) begin
        ovfFlag[regQueue] <= 1'b1;
      end
      if (badPop) begin
        udfFlag[regQueue] <= 1'b1;
      end
      if (doPush) begin
        freeHead <= nextPtr[freeHead];
        freeCnt  <= freeCnt - 1'b1;
        if (qEmpty) begin
          headPtr[regQueue] <= freeHead;
        end else begin
          nextPtr[tailPtr[regQueue]] <= freeHead;
        end
        tailPtr[regQueue] <= freeHead;
        cnt[regQueue]     <= qCnt + 1'b1;
      end
      if (doPop) begin
        headPtr[regQueue]           <= nextPtr[headPtr[regQueue]];
        nextPtr[headPtr[regQueue]]  <= freeHead;
        freeHead                    <= headPtr[regQueue];
        freeCnt                     <= freeCnt + 1'b1;
        cnt[regQueue]               <= qCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/msgq_data.sv
module msgq_data
  import msgq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [DATA_W-1:0] regWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] stage   [WIN_WORDS];
  logic [DATA_W-1:0] base    [WIN_WORDS];
  logic [DATA_W-1:0] slotRam [NUM_SLOTS][WIN_WORDS];

  always_comb begin
    for (int w = 0; w < WIN_WORDS; w++) begin
      base[w] = strb.discard ? '0 : stage[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WIN_WORDS; w++) stage[w] <= '0;
    end else if (strb.lastWr) begin
      for (int w = 0; w < WIN_WORDS; w++) stage[w] <= '0;
    end else if (strb.stageWr) begin
      for (int w = 0; w < WIN_WORDS; w++) begin
        stage[w] <= (WW'(w) == strb.idx) ? regWdata : base[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      for (int w = 0; w < WIN_WORDS; w++) begin
        slotRam[strb.wrSlot][w] <= (w == WIN_WORDS - 1) ? regWdata : base[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rdEn;
      if (strb.rdHead)      rspData <= slotRam[strb.rdSlot][strb.idx];
      else if (strb.rdStat) rspData <= strb.statWord;
      else                  rspData <= '0;
    end
  end
endmodule

// File: rtl/msgq_mgr.sv
module msgq_mgr
  import msgq_pkg::*;
#(
  parameter logic [NUM_Q-1:0] RX_MASK = {{(NUM_Q/2){1'b1}}, {(NUM_Q/2){1'b0}}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regReq,
  input  logic              regWe,
  input  logic [1:0]        regSize,
  input  logic [QW-1:0]     regQueue,
  input  logic [OFFW-1:0]   regWord,
  input  logic [DATA_W-1:0] regWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [NUM_Q-1:0]  irq
);
  dp_strobe_t     strb;
  logic [FCW-1:0] freeCount;

  msgq_ctrl #(.RX_MASK(RX_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe),
    .regSize(regSize), .regQueue(regQueue), .regWord(regWord),
    .regWdata(regWdata), .strb(strb), .irq(irq), .freeCount(freeCount)
  );

  msgq_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: rtl/msgq_mgr_chk.sv
module msgq_mgr_chk
  import msgq_pkg::*;
#(
  parameter logic [NUM_Q-1:0] RX_MASK = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              regReq,
  input logic              regWe,
  input logic [1:0]        regSize,
  input logic [QW-1:0]     regQueue,
  input logic [OFFW-1:0]   regWord,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic [NUM_Q-1:0]  irq,
  input logic [FCW-1:0]    freeCount,
  input logic              commitStb
);
  p_read_resp_r12: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regWe |=> rspValid);

  p_write_silent_r12: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe |=> !rspValid);

  p_subword_inert_r6: assert property (@(posedge clk) disable iff (!rstN)
    regReq && (regSize != SIZE_WORD) |=> $stable(freeCount) && $stable(irq) && (regWe || rspData == '0));

  p_commit_takes_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> freeCount == $past(freeCount) - 1'b1);

  p_rx_irq_after_commit_r11: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe && regSize == SIZE_WORD && regWord == OFFW'(WIN_BASE + WIN_WORDS - 1)
      && RX_MASK[regQueue] && freeCount != '0 |=> irq[$past(regQueue)]);

  p_empty_pop_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regWe && regSize == SIZE_WORD && regWord == OFFW'(WIN_BASE + WIN_WORDS - 1)
      && RX_MASK[regQueue] && !irq[regQueue] |=> rspData == '0);

  p_tx_irq_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~RX_MASK) == '0);
endmodule

bind msgq_mgr msgq_mgr_chk #(.RX_MASK(RX_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regSize(regSize),
  .regQueue(regQueue), .regWord(regWord), .rspValid(rspValid), .rspData(rspData),
  .irq(irq), .freeCount(freeCount), .commitStb(strb.commit)
);

// File: tb/tb_msgq_mgr.sv
module tb_msgq_mgr;
  localparam logic [63:0] RXM = {{32{1'b1}}, {32{1'b0}}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regReq = 1'b0, regWe = 1'b0;
  logic [1:0] regSize = 2'b10;
  logic [5:0] regQueue = '0;
  logic [4:0] regWord = '0;
  logic [31:0] regWdata = '0;
  logic rspValid;
  logic [31:0] rspData;
  logic [63:0] irq;

  always #2 clk = ~clk;

  msgq_mgr #(.RX_MASK(RXM)) dut (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regSize(regSize),
    .regQueue(regQueue), .regWord(regWord), .regWdata(regWdata),
    .rspValid(rspValid), .rspData(rspData), .irq(irq)
  );

  int nCmp = 0, nBad = 0;
  bit done = 0;

  logic [31:0] mdl [64][$];
  bit ovfM [64];
  bit udfM [64];
  logic [31:0] stg [16];
  int stgQ = 0;
  int total = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus(int q);
    logic [31:0] s = '0;
    s[7:0] = 8'(mdl[q].size() / 16);
    s[16] = ovfM[q];
    s[17] = udfM[q];
    return s;
  endfunction

  function automatic logic [63:0] expIrq();
    logic [63:0] v = '0;
    for (int q = 0; q < 64; q++) v[q] = RXM[q] && (mdl[q].size() != 0);
    return v;
  endfunction

  function automatic void modelWrite(int q, int w, logic [1:0] sz, logic [31:0] d);
    if (sz != 2'b10) return;
    if (w == 0) begin
      if (d[16]) ovfM[q] = 0;
      if (d[17]) udfM[q] = 0;
    end else if (w >= 16) begin
      if (q != stgQ) for (int i = 0; i < 16; i++) stg[i] = '0;
      if (w < 31) begin
        stgQ = q;
        stg[w-16] = d;
      end else begin
        if (mdl[q].size() / 16 == 128 || total == 160) ovfM[q] = 1;
        else begin
          for (int i = 0; i < 15; i++) mdl[q].push_back(stg[i]);
          mdl[q].push_back(d);
          total++;
        end
        for (int i = 0; i < 16; i++) stg[i] = '0;
      end
    end
  endfunction

  function automatic logic [31:0] modelRead(int q, int w, logic [1:0] sz);
    logic [31:0] v;
    if (sz != 2'b10) return '0;
    if (w == 0) return expStatus(q);
    if (w < 16) return '0;
    if (mdl[q].size() == 0) begin
      if (w == 31) udfM[q] = 1;
      return '0;
    end
    v = mdl[q][w-16];
    if (w == 31) begin
      for (int i = 0; i < 16; i++) void'(mdl[q].pop_front());
      total--;
    end
    return v;
  endfunction

  task automatic busOp(bit we, int q, int w, logic [1:0] sz, logic [31:0] d,
                       output logic [31:0] rd, output logic rv);
    regReq = 1'b1; regWe = we; regQueue = 6'(q); regWord = 5'(w);
    regSize = sz; regWdata = d;
    @(negedge clk);
    rd = rspData; rv = rspValid;
    regReq = 1'b0; regWe = 1'b0;
  endtask

  task automatic wr(string tag, int q, int w, logic [1:0] sz, logic [31:0] d);
    logic [31:0] rd; logic rv;
    busOp(1'b1, q, w, sz, d, rd, rv);
    modelWrite(q, w, sz, d);
    check({tag, "/R12 no write response"}, 32'(rv), 32'(0));
    check({tag, "/R11 irq lo"}, irq[31:0], expIrq() >> 0);
    check({tag, "/R11 irq hi"}, irq[63:32], 32'(expIrq() >> 32));
  endtask

  task automatic rdc(string tag, int q, int w, logic [1:0] sz);
    logic [31:0] rd, e; logic rv;
    busOp(1'b0, q, w, sz, '0, rd, rv);
    e = modelRead(q, w, sz);
    check({tag, "/R12 read valid"}, 32'(rv), 32'(1));
    check(tag, rd, e);
    check({tag, "/R11 irq hi"}, irq[63:32], 32'(expIrq() >> 32));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    for (int i = 0; i < 16; i++) stg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq after reset", irq[31:0] | irq[63:32], 32'h0);
    rdc("R1 status q40", 40, 0, 2'b10);
    rdc("R1 status q2", 2, 0, 2'b10);

    // R2 / R3: full message, peek then pop
    for (int w = 16; w < 31; w++) wr("R2 stage", 40, w, 2'b10, 32'hA000_0000 + w);
    wr("R2 commit", 40, 31, 2'b10, 32'hA5A5_0031);
    rdc("R2 count", 40, 0, 2'b10);
    for (int w = 16; w < 31; w++) rdc("R3 peek", 40, w, 2'b10);
    rdc("R3 peek again", 40, 20, 2'b10);
    rdc("R3 pop", 40, 31, 2'b10);
    rdc("R3 count after pop", 40, 0, 2'b10);

    // R3 ordering across two messages
    wr("R3 m1", 41, 16, 2'b10, 32'h1111); wr("R3 m1 last", 41, 31, 2'b10, 32'h1F);
    wr("R3 m2", 41, 16, 2'b10, 32'h2222); wr("R3 m2 last", 41, 31, 2'b10, 32'h2F);
    rdc("R3 order first", 41, 16, 2'b10); rdc("R3 order pop1", 41, 31, 2'b10);
    rdc("R3 order second", 41, 16, 2'b10); rdc("R3 order pop2", 41, 31, 2'b10);

    // R4: unwritten words zero, staging cleared after commit
    wr("R4 one word", 40, 18, 2'b10, 32'hDEAD_0018);
    wr("R4 commit", 40, 31, 2'b10, 32'h4);
    wr("R4 commit bare", 40, 31, 2'b10, 32'h5);
    rdc("R4 unwritten", 40, 17, 2'b10); rdc("R4 written", 40, 18, 2'b10);
    rdc("R4 pop", 40, 31, 2'b10);
    rdc("R4 cleared staging", 40, 18, 2'b10); rdc("R4 pop2", 40, 31, 2'b10);

    // R5: switching queue discards partial
    wr("R5 partial q40", 40, 20, 2'b10, 32'hBAD0_0020);
    wr("R5 other q41", 41, 21, 2'b10, 32'h600D_0021);
    wr("R5 commit q41", 41, 31, 2'b10, 32'h41);
    rdc("R5 discarded word", 41, 20, 2'b10);
    rdc("R5 kept word", 41, 21, 2'b10); rdc("R5 pop", 41, 31, 2'b10);

    // R6: sub-word accesses inert
    wr("R6 byte stage", 42, 16, 2'b00, 32'hFFFF_FFFF);
    wr("R6 half commit", 42, 31, 2'b01, 32'h1234);
    wr("R6 byte commit", 42, 31, 2'b00, 32'h12);
    rdc("R6 count unchanged", 42, 0, 2'b10);
    wr("R6 real commit", 42, 31, 2'b10, 32'h42);
    rdc("R6 byte stage ignored", 42, 16, 2'b10);
    rdc("R6 half pop ignored", 42, 31, 2'b01);
    rdc("R6 byte status zero", 42, 0, 2'b00);
    rdc("R6 count still one", 42, 0, 2'b10);
    rdc("R6 full pop", 42, 31, 2'b10);

    // R10: pop from empty
    rdc("R10 empty pop", 43, 31, 2'b10);
    rdc("R10 empty peek", 43, 22, 2'b10);
    rdc("R10 underflow flag", 43, 0, 2'b10);
    // R7: clear flags
    wr("R7 clear none", 43, 0, 2'b10, 32'h0001_0000);
    rdc("R7 udf kept", 43, 0, 2'b10);
    wr("R7 clear udf", 43, 0, 2'b10, 32'h0002_0000);
    rdc("R7 udf cleared", 43, 0, 2'b10);

    // R8: per-queue limit of 128
    for (int i = 0; i < 128; i++) wr("R8 fill", 44, 31, 2'b10, 32'h8000 + i);
    rdc("R8 count 128", 44, 0, 2'b10);
    wr("R8 overflow push", 44, 31, 2'b10, 32'hFFFF);
    rdc("R8 overflow status", 44, 0, 2'b10);
    wr("R7 clear ovf", 44, 0, 2'b10, 32'h0001_0000);
    rdc("R7 ovf cleared", 44, 0, 2'b10);

    // R9: shared store exhausted (160 slots)
    for (int i = 0; i < 32; i++) wr("R9 fill", 45, 31, 2'b10, 32'h9000 + i);
    wr("R9 store full", 46, 31, 2'b10, 32'h9999);
    rdc("R9 status q46", 46, 0, 2'b10);
    rdc("R9 q46 empty pop", 46, 31, 2'b10);
    rdc("R9 pop q44 frees", 44, 31, 2'b10);
    wr("R9 push after free", 46, 31, 2'b10, 32'h9AAA);
    rdc("R9 q46 status", 46, 0, 2'b10);

    // drain to give room, checking FIFO order
    for (int i = 0; i < 127; i++) rdc("R3 drain q44", 44, 31, 2'b10);
    for (int i = 0; i < 32; i++) rdc("R3 drain q45", 45, 31, 2'b10);
    rdc("R11 q46 pop", 46, 31, 2'b10);

    // Tx queue never interrupts
    wr("R11 tx commit", 3, 31, 2'b10, 32'h3);
    rdc("R11 tx count", 3, 0, 2'b10);
    rdc("R11 tx pop", 3, 31, 2'b10);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int qs[4] = '{2, 40, 41, 47};
      int q = qs[$urandom % 4];
      int k = $urandom % 12;
      int w = 16 + ($urandom % 16);
      logic [1:0] sz = ($urandom % 8 == 0) ? 2'($urandom % 2) : 2'b10;
      logic [31:0] d = $urandom;
      if (k < 4)       wr("R2 rnd stage", q, w, sz, d);
      else if (k < 6)  wr("R2 rnd commit", q, 31, sz, d);
      else if (k < 8)  rdc("R3 rnd peek", q, w, sz);
      else if (k < 10) rdc("R3 rnd pop", q, 31, sz);
      else if (k < 11) rdc("R7 rnd status", q, 0, sz);
      else             wr("R7 rnd clear", q, 0, sz, d & 32'h0003_0000);
    end
    for (int q = 0; q < 64; q++) rdc("R7 final status", q, 0, 2'b10);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule